// File: doc/BRIEF.md
# Dual-Clock FIFO with Synchronized Flags

This block moves 36-bit words from a producer running on one clock to a consumer running on another. The two clocks may be unrelated or may be the same clock. Words sit in a 512-entry dual-port array written so that block RAM can be inferred. Each side reports its status only from state that lives in its own clock domain. The write side shows an input-ready flag and an almost-full flag. The read side shows an output-ready flag and an almost-empty flag. Each flag is derived from the opposite pointer after that pointer has passed through a two-flop Gray-code synchronizer.

After the write-side reset, the block opens a configuration window. During this window writes are refused. Software may load the almost-empty and almost-full offsets through the write-clock configuration pins, and then closes the window. If no load happens, both offsets stay at 8. Empty and full are reported by the ready flags, separately from the two threshold flags.

Top module: `xdf_fifo`

## Requirements
- R1: Words are delivered on the read side in the order they were accepted on the write side, with no loss or duplication, while the two clocks run at unrelated frequencies.
- R2: A word is stored only on a rising write-clock edge where `wen` and `in_ready` are both high. A write attempted while `in_ready` is low is dropped and never appears at the read side.
- R3: On a rising read-clock edge where `ren` and `out_ready` are both high, the oldest word appears on `rdata` after that edge. A read attempted while `out_ready` is low is ignored, and `rdata` keeps its previous value.
- R4: `in_ready` is low whenever 512 words are stored.
- R5: `out_ready` is low whenever no word is stored.
- R6: Once the pointers have settled, `almost_full` is high exactly when the free space (512 minus the stored count) is at or below the almost-full offset.
- R7: Once the pointers have settled, `almost_empty` is high exactly when the stored count is at or below the almost-empty offset.
- R8: After the write-side reset, `in_ready` stays low until a `cfg_close` pulse. A `cfg_load` pulse inside this window captures `cfg_ae` and `cfg_af`. A `cfg_load` after the window has closed has no effect.
- R9: If no `cfg_load` occurs during the window, both offsets equal 8.
- R10: When the opposite side moves a pointer, `out_ready` or `in_ready` responds no earlier than two edges of its own port clock after the edge that moved the pointer.
- R11: During and directly after reset, `in_ready` and `almost_full` are low, `out_ready` is low, and `almost_empty` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-port clock |
| wrst | input | 1 | Synchronous active-high reset, write domain |
| wen | input | 1 | Write enable |
| wdata | input | 36 | Word to store |
| in_ready | output | 1 | Space available and configuration window closed |
| almost_full | output | 1 | Free space at or below the almost-full offset |
| cfg_load | input | 1 | Capture both offsets (configuration window only) |
| cfg_ae | input | 10 | Almost-empty offset value |
| cfg_af | input | 10 | Almost-full offset value |
| cfg_close | input | 1 | Ends the configuration window |
| rclk | input | 1 | Read-port clock |
| rrst | input | 1 | Synchronous active-high reset, read domain |
| ren | input | 1 | Read enable |
| rdata | output | 36 | Word read out, registered |
| out_ready | output | 1 | At least one word is stored |
| almost_empty | output | 1 | Stored count at or below the almost-empty offset |

## Verification
The bench builds the block with its default parameters: 36-bit words, a 9-bit address (512 entries) and default offsets of 8. It pairs a 10 ns write clock with a 7.3 ns read clock. With a full array reachable in a few hundred writes, the bench can exercise the full and empty boundaries and both edges of each threshold, for the default offsets and for loaded ones. It can also count the clock edges between a pointer move in one domain and the flag response in the other.

// File: rtl/xdf_pkg.sv
package xdf_pkg;

  localparam int XDF_DEF_OFFSET = 8;

  function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/xdf_gray_ptr.sv
module xdf_gray_ptr #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] bin,
  output logic [W-1:0] bin_nx,
  output logic [W-1:0] gray
);
  logic [31:0] gray_wide;

  assign bin_nx    = bin + W'(inc);
  assign gray_wide = xdf_pkg::bin_to_gray(32'(bin_nx));

  always_ff @(posedge clk) begin
    if (rst) begin
      bin  <= '0;
      gray <= '0;
    end else begin
      bin  <= bin_nx;
      gray <= gray_wide[W-1:0];
    end
  end

  // A Gray pointer seen by the other domain must change in at most one bit per edge
  p_gray_single_step_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gray ^ $past(gray)));

endmodule

// File: rtl/xdf_ptr_sync.sv
module xdf_ptr_sync #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] stage1, stage2;
  logic [31:0]  bin_wide;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= gray_in;
      stage2 <= stage1;
    end
  end

  assign bin_wide = xdf_pkg::gray_to_bin(32'(stage2));
  assign bin_out  = bin_wide[W-1:0];

endmodule

// File: rtl/xdf_ram.sv
module xdf_ram #(
  parameter int DW = 36,
  parameter int AW = 9
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int ENTRIES = 1 << AW;

  logic [DW-1:0] mem [ENTRIES];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/xdf_fifo.sv
module xdf_fifo #(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 9,
  parameter int DEF_AE = xdf_pkg::XDF_DEF_OFFSET,
  parameter int DEF_AF = xdf_pkg::XDF_DEF_OFFSET
) (
  input  logic              wclk,
  input  logic              wrst,
  input  logic              wen,
  input  logic [DATA_W-1:0] wdata,
  output logic              in_ready,
  output logic              almost_full,
  input  logic              cfg_load,
  input  logic [ADDR_W:0]   cfg_ae,
  input  logic [ADDR_W:0]   cfg_af,
  input  logic              cfg_close,
  input  logic              rclk,
  input  logic              rrst,
  input  logic              ren,
  output logic [DATA_W-1:0] rdata,
  output logic              out_ready,
  output logic              almost_empty
);
  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] DEPTH = PW'(1 << ADDR_W);

  // ---------------- write domain ----------------
  logic          cfg_open;
  logic [PW-1:0] ae_off, af_off;
  logic          in_ready_r, af_r;
  logic [PW-1:0] wbin, wbin_nx, wgray, rbin_w;
  logic [PW-1:0] w_used, w_used_nx, w_free_nx;
  logic          w_full_nx, wr_ok;

  // ---------------- read domain -----------------
  logic          out_ready_r, ae_r;
  logic [PW-1:0] rbin, rbin_nx, rgray, wbin_r;
  logic [PW-1:0] r_used_nx;
  logic          rd_ok;

  assign wr_ok = wen & in_ready_r;
  assign rd_ok = ren & out_ready_r;

  xdf_gray_ptr #(.W(PW)) u_wptr (
    .clk(wclk), .rst(wrst), .inc(wr_ok),
    .bin(wbin), .bin_nx(wbin_nx), .gray(wgray)
  );

  xdf_ptr_sync #(.W(PW)) u_rsync (
    .clk(wclk), .rst(wrst), .gray_in(rgray), .bin_out(rbin_w)
  );

  assign w_used    = wbin - rbin_w;
  assign w_used_nx = wbin_nx - rbin_w;
  assign w_full_nx = (w_used_nx == DEPTH);
  assign w_free_nx = DEPTH - w_used_nx;

  always_ff @(posedge wclk) begin
    if (wrst) begin
      cfg_open   <= 1'b1;
      ae_off     <= PW'(DEF_AE);
      af_off     <= PW'(DEF_AF);
      in_ready_r <= 1'b0;
      af_r       <= 1'b0;
    end else begin
      if (cfg_open && cfg_load) begin
        ae_off <= cfg_ae;
        af_off <= cfg_af;
      end
      if (cfg_close) cfg_open <= 1'b0;
      in_ready_r <= !w_full_nx && !(cfg_open && !cfg_close);
      af_r       <= (w_free_nx <= af_off);
    end
  end

  assign in_ready    = in_ready_r;
  assign almost_full = af_r;

  xdf_ram #(.DW(DATA_W), .AW(ADDR_W)) u_ram (
    .wclk(wclk), .we(wr_ok), .waddr(wbin[ADDR_W-1:0]), .wdata(wdata),
    .rclk(rclk), .re(rd_ok), .raddr(rbin[ADDR_W-1:0]), .rdata(rdata)
  );

  xdf_gray_ptr #(.W(PW)) u_rptr (
    .clk(rclk), .rst(rrst), .inc(rd_ok),
    .bin(rbin), .bin_nx(rbin_nx), .gray(rgray)
  );

  xdf_ptr_sync #(.W(PW)) u_wsync (
    .clk(rclk), .rst(rrst), .gray_in(wgray), .bin_out(wbin_r)
  );

  assign r_used_nx = wbin_r - rbin_nx;

  // ae_off is held still once writes are allowed, so it is read here as a static value
  always_ff @(posedge rclk) begin
    if (rrst) begin
      out_ready_r <= 1'b0;
      ae_r        <= 1'b1;
    end else begin
      out_ready_r <= (r_used_nx != '0);
      ae_r        <= (r_used_nx <= ae_off);
    end
  end

  assign out_ready    = out_ready_r;
  assign almost_empty = ae_r;

  // ---------------- assertions ----------------
  p_no_overflow_r2: assert property (@(posedge wclk) disable iff (wrst)
    (wen && !in_ready) |=> $stable(wbin));

  p_full_blocks_r4: assert property (@(posedge wclk) disable iff (wrst)
    (w_used == DEPTH) |-> !in_ready);

  p_count_bound_r4: assert property (@(posedge wclk) disable iff (wrst)
    w_used <= DEPTH);

  p_window_blocks_r8: assert property (@(posedge wclk) disable iff (wrst)
    cfg_open |-> !in_ready);

  p_offsets_frozen_r8: assert property (@(posedge wclk) disable iff (wrst)
    !cfg_open |=> ($stable(ae_off) && $stable(af_off)));

  p_no_underflow_r3: assert property (@(posedge rclk) disable iff (rrst)
    (ren && !out_ready) |=> ($stable(rbin) && $stable(rdata)));

  p_empty_is_low_r7: assert property (@(posedge rclk) disable iff (rrst)
    !out_ready |-> almost_empty);

endmodule

// File: tb/xdf_fifo_test.sv
`timescale 1ns/1ps
module xdf_fifo_test;
  localparam int DW = 36;
  localparam int AW = 9;
  localparam int DEPTH = 1 << AW;

  logic          wclk = 1'b0, rclk = 1'b0;
  logic          wrst = 1'b1, rrst = 1'b1;
  logic          wen = 1'b0, ren = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic          cfg_load = 1'b0, cfg_close = 1'b0;
  logic [AW:0]   cfg_ae = '0, cfg_af = '0;
  logic          in_ready, almost_full, out_ready, almost_empty;
  logic [DW-1:0] rdata;

  xdf_fifo uut (
    .wclk(wclk), .wrst(wrst), .wen(wen), .wdata(wdata),
    .in_ready(in_ready), .almost_full(almost_full),
    .cfg_load(cfg_load), .cfg_ae(cfg_ae), .cfg_af(cfg_af), .cfg_close(cfg_close),
    .rclk(rclk), .rrst(rrst), .ren(ren), .rdata(rdata),
    .out_ready(out_ready), .almost_empty(almost_empty)
  );

  always #5    wclk = ~wclk;
  always #3.65 rclk = ~rclk;

  logic [DW-1:0] model[$];
  int checks = 0, fails = 0, gidx = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int i);
    return {4'(i), 32'(i) ^ 32'h5A5A1234};
  endfunction

  task automatic settle();
    repeat (6) @(negedge wclk);
    repeat (6) @(negedge rclk);
  endtask

  task automatic do_reset();
    wen = 0; ren = 0; cfg_load = 0; cfg_close = 0;
    wrst = 1; rrst = 1;
    repeat (4) @(negedge wclk);
    repeat (4) @(negedge rclk);
    @(negedge wclk) wrst = 0;
    @(negedge rclk) rrst = 0;
    model.delete();
  endtask

  task automatic load_cfg(input int ae, input int af);
    @(negedge wclk); cfg_load = 1; cfg_ae = (AW+1)'(ae); cfg_af = (AW+1)'(af);
    @(negedge wclk); cfg_load = 0;
  endtask

  task automatic close_cfg();
    @(negedge wclk); cfg_close = 1;
    @(negedge wclk); cfg_close = 0;
    chk(in_ready == 1'b1, "R8", "in_ready after close", in_ready, 1);
  endtask

  task automatic write_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      wen = 1; wdata = pat(gidx); gidx++;
      if (in_ready) model.push_back(wdata);
    end
    @(negedge wclk); wen = 0;
  endtask

  task automatic drain(input string req);
    logic          pend = 0;
    logic [DW-1:0] exp = '0;
    int            guard = 0;
    while ((model.size() != 0 || pend) && guard < 20000) begin
      @(negedge rclk);
      guard++;
      if (pend) chk(rdata == exp, req, "read order", rdata, exp);
      pend = 0;
      ren = 1;
      if (out_ready && model.size() != 0) begin pend = 1; exp = model.pop_front(); end
    end
    @(negedge rclk); ren = 0;
  endtask

  task automatic t_reset_state();
    do_reset();
    @(negedge wclk);
    chk(in_ready == 0,     "R11", "in_ready", in_ready, 0);
    chk(almost_full == 0,  "R11", "almost_full", almost_full, 0);
    @(negedge rclk);
    chk(out_ready == 0,    "R11", "out_ready", out_ready, 0);
    chk(almost_empty == 1, "R11", "almost_empty", almost_empty, 1);
    // R8: window holds writes back
    write_n(3);
    chk(model.size() == 0, "R8", "writes accepted in window", model.size(), 0);
    settle();
    chk(out_ready == 0, "R8", "out_ready after blocked writes", out_ready, 0);
  endtask

  task automatic t_defaults_and_bounds();
    logic [DW-1:0] held;
    do_reset();
    close_cfg();
    write_n(8);  settle();
    chk(almost_empty == 1, "R9", "ae at count 8", almost_empty, 1);
    write_n(1);  settle();
    chk(almost_empty == 0, "R9", "ae at count 9", almost_empty, 0);
    write_n(494); settle();
    chk(almost_full == 0, "R9", "af at free 9", almost_full, 0);
    write_n(1);  settle();
    chk(almost_full == 1, "R9", "af at free 8", almost_full, 1);
    write_n(8);  settle();
    chk(model.size() == DEPTH, "R4", "stored count", model.size(), DEPTH);
    chk(in_ready == 0, "R4", "in_ready when full", in_ready, 0);
    @(negedge wclk); wen = 1; wdata = '1;
    @(negedge wclk); wen = 0;
    drain("R1");
    settle();
    chk(out_ready == 0, "R2", "out_ready after drain (dropped word absent)", out_ready, 0);
    chk(out_ready == 0, "R5", "out_ready when empty", out_ready, 0);
    held = rdata;
    @(negedge rclk); ren = 1;
    repeat (3) @(negedge rclk);
    ren = 0;
    chk(rdata == held, "R3", "rdata held on empty read", rdata, held);
    chk(out_ready == 0, "R3", "out_ready after empty read", out_ready, 0);
  endtask

  task automatic t_loaded_offsets();
    do_reset();
    load_cfg(20, 30);
    close_cfg();
    load_cfg(1, 1);   // outside window: no effect
    write_n(20); settle();
    chk(almost_empty == 1, "R7", "ae at count 20", almost_empty, 1);
    write_n(1);  settle();
    chk(almost_empty == 0, "R7", "ae at count 21", almost_empty, 0);
    chk(almost_full == 0, "R8", "late load ignored (af)", almost_full, 0);
    write_n(460); settle();
    chk(almost_full == 0, "R6", "af at free 31", almost_full, 0);
    write_n(1);  settle();
    chk(almost_full == 1, "R6", "af at free 30", almost_full, 1);
    drain("R1");
  endtask

  task automatic t_latency();
    int n;
    logic [DW-1:0] exp;
    do_reset();
    close_cfg();
    settle();
    @(negedge wclk); wen = 1; wdata = pat(gidx); gidx++; model.push_back(wdata);
    @(posedge wclk); wen <= 1'b0;
    n = 0;
    while (n < 30) begin
      @(posedge rclk); n++;
      @(negedge rclk);
      if (out_ready) break;
    end
    chk(n >= 2 && n < 30, "R10", "rclk edges to out_ready", n, 3);
    drain("R1");
    write_n(DEPTH); settle();
    chk(in_ready == 0, "R4", "in_ready full before read", in_ready, 0);
    @(negedge rclk); ren = 1; exp = model.pop_front();
    @(posedge rclk); ren <= 1'b0;
    @(negedge rclk);
    chk(rdata == exp, "R3", "single read data", rdata, exp);
    n = 0;
    while (n < 30) begin
      @(posedge wclk); n++;
      @(negedge wclk);
      if (in_ready) break;
    end
    chk(n >= 2 && n < 30, "R10", "wclk edges to in_ready", n, 3);
    drain("R1");
  endtask

  task automatic t_stream();
    int got = 0;
    do_reset();
    close_cfg();
    fork
      begin
        int acc = 0;
        int k = 0;
        while (acc < 600) begin
          @(negedge wclk);
          if (in_ready && (k % 4 != 3)) begin
            wen = 1; wdata = pat(gidx); gidx++; model.push_back(wdata); acc++;
          end else wen = 0;
          k++;
        end
        @(negedge wclk); wen = 0;
      end
      begin
        logic          pend = 0;
        logic [DW-1:0] exp = '0;
        int k = 0;
        while (got < 600) begin
          @(negedge rclk);
          if (pend) begin
            chk(rdata == exp, "R1", "stream order", rdata, exp);
            got++;
          end
          pend = 0;
          if (out_ready && (k % 3 != 1) && model.size() != 0) begin
            ren = 1; pend = 1; exp = model.pop_front();
          end else ren = 0;
          k++;
        end
        ren = 0;
      end
    join
    settle();
    chk(out_ready == 0, "R5", "empty after stream", out_ready, 0);
  endtask

  initial begin
    #2ms;
    fails++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset_state();
    t_defaults_and_bounds();
    t_loaded_offsets();
    t_latency();
    t_stream();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule